// File: doc/BRIEF.md
# RTC Interrupt Flag and Enable Unit

This unit merges the three event sources of a real-time clock onto one active-low interrupt request. The sources are a periodic tick, an alarm match and the end of the once-per-second update. The periodic tick is made inside the unit by dividing a 32.768 kHz base strobe. A 4-bit rate code chooses the division. The alarm and update-end events are single-cycle pulses that arrive from the clock core.

Each event sets its own flag in an 8-bit status word, whether or not that source is enabled. Three enable inputs decide which flags may pull the request line low. Bit 7 of the status word is a summary bit. It is set when any flag is set together with its enable. An interrupt handler reads the status word and masks it with the enables to find the causes. The read also clears every flag.

The status word has fixed bit positions. Bit 6 is periodic, bit 5 is alarm, bit 4 is update-end, bit 7 is the summary, and bits 3:0 always read zero.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, `stat_c` is 0x00 and `irq_n` is 1.
- R2: An `alarm_hit` pulse sets bit 5 of `stat_c` on the next clock edge, whether or not `ena_alarm` is set.
- R3: An `update_end` pulse sets bit 4 of `stat_c` on the next clock edge. With `ena_update` set, it also drives `irq_n` low.
- R4: For `rate_sel` values 3 to 15, bit 6 of `stat_c` is set on the 2^(rate_sel-1)-th `base_tick` after reset. That gives 8.192 kHz at value 3 down to 2 Hz at value 15.
- R5: A `rate_sel` of 0 stops the periodic source, and bit 6 is never set.
- R6: `rate_sel` values 1 and 2 give the same period as values 3 and 4.
- R7: A `stat_rd` strobe returns the current flags on `stat_c` in that same cycle. The flags are cleared on the following clock edge, and `irq_n` returns to 1.
- R8: An event that arrives in the same cycle as `stat_rd` leaves its flag set after the clear.
- R9: Bit 7 of `stat_c` is 1 exactly when a flag is set together with its enable. Bits 3:0 read as 0.
- R10: `irq_n` equals the inverse of bit 7. It stays low until a read clears the enabled flags, and setting an enable while its flag is already pending drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | One-cycle strobe at the 32.768 kHz base rate |
| rate_sel | input | 4 | Periodic rate code: 0 turns the source off |
| ena_periodic | input | 1 | Periodic source may raise the interrupt |
| ena_alarm | input | 1 | Alarm source may raise the interrupt |
| ena_update | input | 1 | Update-end source may raise the interrupt |
| alarm_hit | input | 1 | Alarm match event pulse |
| update_end | input | 1 | Update cycle complete event pulse |
| stat_rd | input | 1 | Host read strobe of the status word; clears the flags |
| stat_c | output | 8 | Status word: summary, event flags, zero low nibble |
| irq_n | output | 1 | Interrupt request, active low, level |

## Verification
The assertions assume that `stat_rd` is a single-cycle strobe. They also assume that the event inputs are pulses that are clean after reset, and that `rate_sel` and the enables are steady while a request is pending. The bench changes every input only on the falling edge. It holds `rate_sel` constant through each divider run and resets the unit before each run, so each run starts from a known divider count. Read strobes last one cycle. Enables are changed only at points where the expected level on `irq_n` is worked out again before the next check.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NSRC     = 3;
  localparam int STAT_W   = 8;
  localparam int SUM_BIT  = 7;
  localparam int FLAG_LSB = 4;
  // source index i maps to status bit FLAG_LSB+i
  localparam int SRC_UPD  = 0;
  localparam int SRC_ALM  = 1;
  localparam int SRC_PER  = 2;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
  parameter int CNT_W = 15,
  parameter int RS_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [RS_W-1:0] rate,
  output logic            pulse
);
  logic [CNT_W-1:0] cnt;
  logic [RS_W-1:0]  eff;
  logic [CNT_W-1:0] mask;

  // codes 1 and 2 fall back to the fastest usable taps
  always_comb begin
    eff = rate;
    if (rate == RS_W'(1))      eff = RS_W'(3);
    else if (rate == RS_W'(2)) eff = RS_W'(4);
  end

  always_comb begin
    if (rate == '0) mask = '0;
    else            mask = (CNT_W'(1) << (eff - RS_W'(1))) - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + CNT_W'(1);
  end

  assign pulse = tick && (rate != '0) && ((cnt & mask) == mask);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  logic     rd,
  output src_vec_t flags
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (rd)     flags[i] <= 1'b0;
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
  end

  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && evt == '0) |=> flags == '0);

  assert_kept_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && evt != '0) |=> flags != '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && evt == '0) |=> $stable(flags));
endmodule

// File: rtl/rtc_irq_merge.sv
module rtc_irq_merge
  import rtc_irq_pkg::*;
(
  input  src_vec_t            flags,
  input  src_vec_t            en,
  output logic [STAT_W-1:0]   stat,
  output logic                irq_n
);
  logic hit;
  assign hit = |(flags & en);

  always_comb begin
    stat = '0;
    for (int i = 0; i < NSRC; i++) stat[FLAG_LSB+i] = flags[i];
    stat[SUM_BIT] = hit;
  end

  assign irq_n = ~hit;
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int RS_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_tick,
  input  logic [RS_W-1:0] rate_sel,
  input  logic            ena_periodic,
  input  logic            ena_alarm,
  input  logic            ena_update,
  input  logic            alarm_hit,
  input  logic            update_end,
  input  logic            stat_rd,
  output logic [7:0]      stat_c,
  output logic            irq_n
);
  logic     per_pulse;
  src_vec_t evt, en, flags;

  rtc_rate_div #(.CNT_W(CNT_W), .RS_W(RS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .rate(rate_sel), .pulse(per_pulse)
  );

  always_comb begin
    evt = '0;
    evt[SRC_PER] = per_pulse;
    evt[SRC_ALM] = alarm_hit;
    evt[SRC_UPD] = update_end;
    en = '0;
    en[SRC_PER] = ena_periodic;
    en[SRC_ALM] = ena_alarm;
    en[SRC_UPD] = ena_update;
  end

  rtc_flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd(stat_rd), .flags(flags)
  );

  rtc_irq_merge u_merge (
    .flags(flags), .en(en), .stat(stat_c), .irq_n(irq_n)
  );

  assert_rate_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0 && stat_rd) |=> !stat_c[FLAG_LSB+SRC_PER]);

  assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !stat_rd && $stable({ena_periodic, ena_alarm, ena_update}))
      |=> !irq_n);

  assert_update_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    update_end |=> stat_c[FLAG_LSB+SRC_UPD]);
endmodule

// File: tb/rtc_irq_unit_tb.sv
module rtc_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [3:0] RS_V  [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd15};
  localparam int         PER_V [NV] = '{0, 4, 8, 4, 8, 16, 128, 16384};

  logic clk = 1'b0, rst_n = 1'b0;
  logic base_tick = 0, ena_periodic = 0, ena_alarm = 0, ena_update = 0;
  logic alarm_hit = 0, update_end = 0, stat_rd = 0;
  logic [3:0] rate_sel = 0;
  logic [7:0] stat_c;
  logic irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_sel(rate_sel),
    .ena_periodic(ena_periodic), .ena_alarm(ena_alarm), .ena_update(ena_update),
    .alarm_hit(alarm_hit), .update_end(update_end), .stat_rd(stat_rd),
    .stat_c(stat_c), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 stat", stat_c, 8'h00);
    chk("R1 irq", {7'd0, irq_n}, 8'h01);

    // table: periodic rate per code (R4, R5, R6)
    for (int v = 0; v < NV; v++) begin
      string req;
      req = (RS_V[v] == 0) ? "R5" : ((RS_V[v] < 3) ? "R6" : "R4");
      do_reset();
      rate_sel = RS_V[v];
      ena_periodic = 1; ena_alarm = 1; ena_update = 1;
      base_tick = 1;
      if (PER_V[v] == 0) begin
        repeat (64) @(negedge clk);
        base_tick = 0;
        chk(req, stat_c, 8'h00);
      end else begin
        repeat (PER_V[v] - 1) @(negedge clk);
        chk(req, {1'b0, stat_c[6], 6'd0}, 8'h00);
        @(negedge clk);
        base_tick = 0;
        chk(req, stat_c, 8'hC0);
        chk("R10 periodic irq", {7'd0, irq_n}, 8'h00);
      end
    end

    // directed: alarm while disabled (R2, R9)
    do_reset();
    rate_sel = 0; ena_periodic = 0; ena_alarm = 0; ena_update = 0;
    alarm_hit = 1;
    @(negedge clk);
    alarm_hit = 0;
    chk("R2 flag no enable", stat_c, 8'h20);
    chk("R2 irq stays high", {7'd0, irq_n}, 8'h01);
    ena_alarm = 1;
    #1;
    chk("R9 summary", stat_c, 8'hA0);
    chk("R10 late enable", {7'd0, irq_n}, 8'h00);

    // read and clear (R7)
    @(negedge clk);
    stat_rd = 1;
    chk("R7 read value", stat_c, 8'hA0);
    @(negedge clk);
    stat_rd = 0;
    chk("R7 cleared", stat_c, 8'h00);
    chk("R7 irq released", {7'd0, irq_n}, 8'h01);

    // update-end enabled (R3, R10 hold)
    ena_alarm = 0; ena_update = 1;
    update_end = 1;
    @(negedge clk);
    update_end = 0;
    chk("R3 update flag", stat_c, 8'h90);
    repeat (5) @(negedge clk);
    chk("R10 held low", {7'd0, irq_n}, 8'h00);

    // read with simultaneous alarm (R8)
    stat_rd = 1; alarm_hit = 1;
    @(negedge clk);
    stat_rd = 0; alarm_hit = 0;
    chk("R8 kept flag", stat_c, 8'h20);
    chk("R8 irq disabled source", {7'd0, irq_n}, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule